// File: doc/BRIEF.md
# Serial Port Expander Register Controller

This block is the register side of a serially addressed 8-bit bidirectional port. A serial shift front end turns the wire traffic into whole bytes and hands each one over with a one-cycle `rx_valid` strobe. The controller hands back, through `tx_byte` and `tx_oe`, the byte the front end must shift out next. The first byte after the chip enable goes active is a control byte. Every byte after it is data: a store value, a bit mask, or a dummy byte that clocks out read data.

The controller holds a value register and a direction register. It drives the port's per-pin output enables and output levels from these two registers. It also reads the synchronized pin levels back. A compare unit outside the block uses the mode bits of the last accepted control byte. The compare unit's flag is sampled once, when the chip enable goes active, and is shown to the host while the control byte is being shifted.

Top module: `spx_regctl`

## Requirements
- R1: After reset, `port_oe`, `port_out`, `tx_oe` and `cmp_mode` are all zero, so every pin is an input.
- R2: The transaction goes on only if control-byte bits [7:6] equal `strap_id`. Otherwise `tx_oe` stays low and every later byte is discarded until `cs_act` falls.
- R3: Control bit 5 picks the register: 0 is the value register and 1 is the direction register. Control bit 4 equal to 1 means write and 0 means read. A single data byte changes at most one register.
- R4: On a write with control bit 3 equal to 0, the data byte replaces the selected register.
- R5: On a write with control bits [3:2] = 10, each 1 in the data byte clears the matching register bit. Each 0 leaves the bit as it was.
- R6: On a write with control bits [3:2] = 11, each 1 in the data byte sets the matching register bit. Each 0 leaves the bit as it was.
- R7: On a read, control bits [3:2] have no effect, and neither register changes.
- R8: `port_oe` equals the direction register, where 1 means the pin drives. `port_out` equals the value register.
- R9: A read of the value register returns `pin_in` for bits whose direction is 0 and the stored value for bits whose direction is 1. A read of the direction register returns it unchanged.
- R10: While the data byte of a write is pending, `tx_byte` holds the old contents of the selected register. The register and the port update in the cycle after that byte's `rx_valid`.
- R11: During a read, `cs_act` held high lets any number of data bytes follow. `tx_byte` keeps presenting the current read value, including live pin changes.
- R12: After a completed write, further bytes are discarded and `tx_oe` stays low until `cs_act` falls.
- R13: If `cs_act` falls before the data byte of a write, both registers are unchanged. One cycle after `cs_act` is low, `tx_oe` is low.
- R14: `cmp_flag` is sampled in the cycle `cs_act` goes active. While the control byte is pending, `tx_byte` is that flag in bit 0 with zeros above it. `cmp_mode` takes control bits [1:0] of each control byte whose identity matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_act | input | 1 | Chip enable, active high, from the front end |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| strap_id | input | 2 | Identity straps |
| pin_in | input | 8 | Synchronized pin levels |
| cmp_flag | input | 1 | Flag from the compare unit |
| tx_byte | output | 8 | Byte to shift out next |
| tx_oe | output | 1 | Serial output drive enable |
| port_out | output | 8 | Pin output levels |
| port_oe | output | 8 | Pin output enables |
| cmp_mode | output | 2 | Compare mode for the compare unit |

## Verification
The bench runs each write mode on both registers and checks the old-value echo. A design that swapped the clear and set masks, or that shifted out the new value, fails those checks. Reads use mixed direction bits, with pin levels that differ from the stored bits, and a streaming read changes the pins between bytes. A read mux that ignored the direction register, or that latched the read value once, is caught there. An identity mismatch, an aborted write and an extra byte after a write are each followed by a port check. A design that fell through to a store in any of these cases would change the port.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 2;
    localparam int DF_W   = 2;
    localparam int CM_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } spx_state_e;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            rs;
        logic            wr;
        logic [DF_W-1:0] df;
        logic [CM_W-1:0] cm;
    } spx_ctrl_t;
endpackage

// File: rtl/spx_ctrl_decode.sv
module spx_ctrl_decode
    import spx_pkg::*;
(
    input  logic [BYTE_W-1:0] ctrl_byte,
    input  logic [ID_W-1:0]   strap,
    output spx_ctrl_t         ctrl,
    output logic              id_ok
);
    always_comb begin
        ctrl  = spx_ctrl_t'(ctrl_byte);
        id_ok = (ctrl.id == strap);
    end
endmodule

// File: rtl/spx_reg_update.sv
module spx_reg_update
    import spx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0]    old_val,
    input  logic [W-1:0]    mask,
    input  logic [DF_W-1:0] df,
    output logic [W-1:0]    new_val
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (!df[1])
                new_val[b] = mask[b];
            else if (df[0])
                new_val[b] = old_val[b] | mask[b];
            else
                new_val[b] = old_val[b] & ~mask[b];
        end
    end
endmodule

// File: rtl/spx_read_mux.sv
module spx_read_mux
    import spx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         sel_dir,
    input  logic [W-1:0] val_reg,
    input  logic [W-1:0] dir_reg,
    input  logic [W-1:0] pins,
    output logic [W-1:0] rd_val
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (sel_dir)
                rd_val[b] = dir_reg[b];
            else
                rd_val[b] = dir_reg[b] ? val_reg[b] : pins[b];
        end
    end
endmodule

// File: rtl/spx_regctl.sv
module spx_regctl
    import spx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ID_W-1:0]   strap_id,
    input  logic [BYTE_W-1:0] pin_in,
    input  logic              cmp_flag,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_oe,
    output logic [BYTE_W-1:0] port_out,
    output logic [BYTE_W-1:0] port_oe,
    output logic [CM_W-1:0]   cmp_mode
);
    typedef struct packed {
        spx_state_e       st;
        logic [BYTE_W-1:0] val;
        logic [BYTE_W-1:0] dir;
        logic              rs;
        logic [DF_W-1:0]   df;
        logic [CM_W-1:0]   cm;
        logic              flag;
    } regs_t;

    regs_t q, d;

    spx_ctrl_t         ctl;
    logic              id_ok;
    logic [BYTE_W-1:0] old_sel;
    logic [BYTE_W-1:0] upd_val;
    logic [BYTE_W-1:0] rd_val;

    spx_ctrl_decode u_dec (
        .ctrl_byte (rx_byte),
        .strap     (strap_id),
        .ctrl      (ctl),
        .id_ok     (id_ok)
    );

    assign old_sel = q.rs ? q.dir : q.val;

    spx_reg_update #(.W(BYTE_W)) u_upd (
        .old_val (old_sel),
        .mask    (rx_byte),
        .df      (q.df),
        .new_val (upd_val)
    );

    spx_read_mux #(.W(BYTE_W)) u_rd (
        .sel_dir (q.rs),
        .val_reg (q.val),
        .dir_reg (q.dir),
        .pins    (pin_in),
        .rd_val  (rd_val)
    );

    always_comb begin
        d = q;
        if (!cs_act) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    d.st   = ST_CTRL;
                    d.flag = cmp_flag;
                end
                ST_CTRL: begin
                    if (rx_valid) begin
                        if (id_ok) begin
                            d.rs = ctl.rs;
                            d.df = ctl.df;
                            d.cm = ctl.cm;
                            d.st = ctl.wr ? ST_WDATA : ST_RDATA;
                        end else begin
                            d.st = ST_DONE;
                        end
                    end
                end
                ST_WDATA: begin
                    if (rx_valid) begin
                        if (q.rs) d.dir = upd_val;
                        else      d.val = upd_val;
                        d.st = ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_CTRL:  tx_byte = {{(BYTE_W-1){1'b0}}, q.flag};
            ST_WDATA: tx_byte = old_sel;
            ST_RDATA: tx_byte = rd_val;
            default:  tx_byte = '0;
        endcase
        tx_oe = (q.st == ST_CTRL) || (q.st == ST_WDATA) || (q.st == ST_RDATA);
    end

    assign port_out = q.val;
    assign port_oe  = q.dir;
    assign cmp_mode = q.cm;
endmodule

// File: rtl/spx_regctl_chk.sv
module spx_regctl_chk
    import spx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              rx_valid,
    input logic              tx_oe,
    input logic [BYTE_W-1:0] port_out,
    input logic [BYTE_W-1:0] port_oe,
    input logic [CM_W-1:0]   cmp_mode
);
    assert_port_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(port_out) && $stable(port_oe)));

    assert_one_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> ($stable(port_out) || $stable(port_oe)));

    assert_quiet_after_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !tx_oe);

    assert_mode_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(cmp_mode));
endmodule

bind spx_regctl spx_regctl_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .rx_valid (rx_valid),
    .tx_oe    (tx_oe),
    .port_out (port_out),
    .port_oe  (port_oe),
    .cmp_mode (cmp_mode)
);

// File: tb/test_spx_regctl.sv
`timescale 1ns/1ps
module test_spx_regctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_act = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [1:0] strap_id = 2'b10;
    logic [7:0] pin_in = '0;
    logic       cmp_flag = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_oe;
    logic [7:0] port_out;
    logic [7:0] port_oe;
    logic [1:0] cmp_mode;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spx_regctl i_spx_regctl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .strap_id(strap_id), .pin_in(pin_in),
        .cmp_flag(cmp_flag), .tx_byte(tx_byte), .tx_oe(tx_oe),
        .port_out(port_out), .port_oe(port_oe), .cmp_mode(cmp_mode)
    );

    // fields: control, data, pins, expected tx during data byte, expected port_out, expected port_oe
    localparam logic [47:0] VEC [8] = '{
        {8'hB0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hF0},  // R4 R3 plain write direction
        {8'h90, 8'hA5, 8'h00, 8'h00, 8'hA5, 8'hF0},  // R4 plain write value
        {8'h9C, 8'h0A, 8'h00, 8'hA5, 8'hAF, 8'hF0},  // R6 set mask value
        {8'h98, 8'h81, 8'h00, 8'hAF, 8'h2E, 8'hF0},  // R5 clear mask value
        {8'hB8, 8'h30, 8'h00, 8'hF0, 8'h2E, 8'hC0},  // R5 clear mask direction
        {8'hBC, 8'h03, 8'h00, 8'hC0, 8'h2E, 8'hC3},  // R6 set mask direction
        {8'h8C, 8'hFF, 8'h5A, 8'h1A, 8'h2E, 8'hC3},  // R9 R7 read value, DF ignored
        {8'hA0, 8'h00, 8'h00, 8'hC3, 8'h2E, 8'hC3}   // R9 read direction
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic open_cs();
        @(negedge clk);
        cs_act = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_cs();
        @(negedge clk);
        cs_act = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 port_oe", port_oe, 8'h00);
        chk("R1 port_out", port_out, 8'h00);
        chk("R1 tx_oe", {7'b0, tx_oe}, 8'h00);
        chk("R1 cmp_mode", {6'b0, cmp_mode}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            pin_in = VEC[i][31:24];
            open_cs();
            send(VEC[i][47:40]);
            chk("R10 R11 tx during data byte", tx_byte, VEC[i][23:16]);
            send(VEC[i][39:32]);
            chk("R8 R4 R5 R6 port_out", port_out, VEC[i][15:8]);
            chk("R8 R3 port_oe", port_oe, VEC[i][7:0]);
            close_cs();
        end

        // R2 identity mismatch: write of FF to the value register with id 01
        open_cs();
        send(8'h50);
        chk("R2 tx_oe after mismatch", {7'b0, tx_oe}, 8'h00);
        send(8'hFF);
        chk("R2 port_out unchanged", port_out, 8'h2E);
        close_cs();

        // R13 aborted write
        open_cs();
        send(8'h90);
        close_cs();
        chk("R13 port_out after abort", port_out, 8'h2E);
        chk("R13 tx_oe after abort", {7'b0, tx_oe}, 8'h00);

        // R12 extra bytes after a write are discarded
        open_cs();
        send(8'h9C);
        send(8'h01);
        chk("R12 write applied", port_out, 8'h2F);
        chk("R12 tx_oe after write", {7'b0, tx_oe}, 8'h00);
        send(8'hFF);
        chk("R12 extra byte discarded", port_out, 8'h2F);
        close_cs();

        // R11 streaming read with live pins, dir C3, value 2F
        pin_in = 8'hFF;
        open_cs();
        send(8'h80);
        chk("R11 first byte", tx_byte, 8'h3F);
        send(8'h00);
        pin_in = 8'h00;
        @(negedge clk);
        chk("R11 second byte live pins", tx_byte, 8'h03);
        send(8'h00);
        chk("R11 third byte", tx_byte, 8'h03);
        chk("R11 tx_oe held", {7'b0, tx_oe}, 8'h01);
        close_cs();

        // R14 compare flag sample and mode bits
        cmp_flag = 1'b1;
        open_cs();
        cmp_flag = 1'b0;
        chk("R14 flag in control phase", tx_byte, 8'h01);
        send(8'h83);
        chk("R14 cmp_mode", {6'b0, cmp_mode}, 8'h03);
        close_cs();
        open_cs();
        chk("R14 flag clear", tx_byte, 8'h00);
        send(8'h41);
        chk("R14 cmp_mode kept on mismatch", {6'b0, cmp_mode}, 8'h03);
        close_cs();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule